// File: doc/BRIEF.md
# Debug-Board Interrupt Aggregator Register Bank

This block is the register bank of a debug expansion board. It gathers level interrupt requests from up to sixteen on-board sources into a sticky status register. A mask register gates those bits. The block then drives a single active-low, level-sensitive interrupt line to the host processor. In the default assignment, bit 0 is the Ethernet controller, bits 1 and 2 are two external UARTs, and bits 3 and 4 are two push buttons. Status bits are cleared through a separate clear register. The host writes ones to clear the chosen bits, then writes zero to let them latch again.

The host reaches the bank through a synchronous 16-bit read/write port with a byte address, and read data arrives one cycle after the read strobe. To confirm that the board is present, the host reads three fixed identification words. A code version word and a board ID word are also readable. The bank further provides an LED output register and a readable copy of the button inputs, which pass through a two-flop synchronizer.

Top module: `dbg_irq_regbank`

## Requirements
- R1: Offsets 0x40, 0x48 and 0x58 are read-only and return 0xAAAA, 0x5555 and 0xCAFE. Writes to these offsets change nothing.
- R2: Offset 0x50 returns the VERSION parameter (default 0x0103) and offset 0x68 returns the BOARD_ID parameter (default 0x00B5). Both are read-only.
- R3: A read from any offset that is not mapped (for example 0x18, 0x30 or 0xFE) returns 0.
- R4: After a synchronous reset, the mask at 0x38 reads 0xFFFF, and the status at 0x10, the clear register at 0x20 and the LED register at 0x00 all read 0. The interrupt line is high.
- R5: A status bit sets on any clock edge where its request is high and its clear bit is 0. It stays set after the request falls.
- R6: A status bit whose clear bit at 0x20 is 1 is cleared on the next clock edge. It stays 0 while that clear bit remains 1, even if its request is high. Once 0 is written back, the bit latches again.
- R7: A mask bit of 1 blocks its source from the interrupt line, but the status bit still latches and can still be read. A mask bit of 0 lets the source through.
- R8: The interrupt output is low exactly when (status AND NOT mask) was non-zero on the previous clock edge, so it lags a status change by one cycle.
- R9: The host start-up sequence must leave status at 0 and mask at 0x001F. The sequence is: write mask 0, write 0xFFFF to 0x20, write 0 to 0x20, write 0x1F to mask. After it, requests on bits 0 to 4 keep the line high, and a request on bit 7 drives the line low.
- R10: The LED register at 0x00 reads back the value written to it. Its low NUM_LED bits drive the LED outputs.
- R11: Offset 0x08 returns the button inputs delayed by two synchronizer flops. A read issued on the first edge after a button change still returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 16 | Read data, valid the cycle after the strobe |
| irq_req | input | NUM_SRC | Level interrupt requests from the sources |
| btn_in | input | NUM_BTN | Asynchronous button inputs |
| led_out | output | NUM_LED | LED drive |
| host_irq_n | output | 1 | Combined interrupt to the host, active low |

## Verification
A table of reads covers every fixed word, the reset values of the writable registers and several holes in the map. This separates a correct address decode from swapped or aliased offsets. The interrupt path is driven first with a single source and the mask open, then with that source masked, then with the clear bit held while the request stays high. These three cases separate sticky latching, mask gating and clear priority. The host start-up sequence is then replayed, followed by a request on a masked low bit and one on an unmasked high bit, which shows that the line follows only unmasked sources. A button change read back one edge and three edges later exposes the synchronizer depth.

// File: rtl/dbg_regbank_pkg.sv
package dbg_regbank_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_LED    = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_BTN    = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_CLEAR  = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_MASK   = 8'h38;
  localparam logic [ADDR_W-1:0] OFS_ID_A   = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_ID_B   = 8'h48;
  localparam logic [ADDR_W-1:0] OFS_VER    = 8'h50;
  localparam logic [ADDR_W-1:0] OFS_ID_C   = 8'h58;
  localparam logic [ADDR_W-1:0] OFS_BOARD  = 8'h68;

  localparam logic [DATA_W-1:0] ID_A_WORD = 16'hAAAA;
  localparam logic [DATA_W-1:0] ID_B_WORD = 16'h5555;
  localparam logic [DATA_W-1:0] ID_C_WORD = 16'hCAFE;

  typedef struct packed {
    logic [DATA_W-1:0] led;
    logic [DATA_W-1:0] btn;
    logic [DATA_W-1:0] status;
    logic [DATA_W-1:0] clear;
    logic [DATA_W-1:0] mask;
  } regview_t;
endpackage

// File: rtl/dbg_sync2.sv
module dbg_sync2 #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/dbg_irq_core.sv
module dbg_irq_core
  import dbg_regbank_pkg::*;
#(
  parameter int NUM_SRC = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mask_we,
  input  logic              clr_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NUM_SRC-1:0] irq_req,
  output logic [DATA_W-1:0] status_o,
  output logic [DATA_W-1:0] mask_o,
  output logic [DATA_W-1:0] clr_o,
  output logic              irq_n
);
  logic [NUM_SRC-1:0] status_q, mask_q, clr_q;
  logic               irq_n_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      mask_q   <= '1;
      clr_q    <= '0;
      irq_n_q  <= 1'b1;
    end else begin
      // clear holds priority over a new request
      status_q <= (status_q | irq_req) & ~clr_q;
      if (mask_we) mask_q <= wdata[NUM_SRC-1:0];
      if (clr_we)  clr_q  <= wdata[NUM_SRC-1:0];
      irq_n_q  <= ~|(status_q & ~mask_q);
    end
  end

  assign irq_n = irq_n_q;

  generate
    if (NUM_SRC < DATA_W) begin : g_pad
      assign status_o = {{(DATA_W-NUM_SRC){1'b0}}, status_q};
      assign clr_o    = {{(DATA_W-NUM_SRC){1'b0}}, clr_q};
      assign mask_o   = {{(DATA_W-NUM_SRC){1'b1}}, mask_q};
    end else begin : g_full
      assign status_o = status_q;
      assign clr_o    = clr_q;
      assign mask_o   = mask_q;
    end
  endgenerate

  assert_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status_q & $past(status_q & ~clr_q)) == $past(status_q & ~clr_q)));

  assert_clear_wins_R6: assert property (@(posedge clk) disable iff (rst)
    (clr_q != '0) |=> ((status_q & $past(clr_q)) == '0));

  assert_irq_level_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_n == ~|$past(status_q & ~mask_q)));

  assert_mask_reset_R4: assert property (@(posedge clk)
    $past(rst) |-> (mask_q == '1 && status_q == '0 && irq_n));
endmodule

// File: rtl/dbg_read_mux.sv
module dbg_read_mux
  import dbg_regbank_pkg::*;
#(
  parameter logic [DATA_W-1:0] VERSION  = 16'h0103,
  parameter logic [DATA_W-1:0] BOARD_ID = 16'h00B5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  regview_t          regs,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] sel, rdata_q;

  always_comb begin
    unique case (addr)
      OFS_LED:    sel = regs.led;
      OFS_BTN:    sel = regs.btn;
      OFS_STATUS: sel = regs.status;
      OFS_CLEAR:  sel = regs.clear;
      OFS_MASK:   sel = regs.mask;
      OFS_ID_A:   sel = ID_A_WORD;
      OFS_ID_B:   sel = ID_B_WORD;
      OFS_VER:    sel = VERSION;
      OFS_ID_C:   sel = ID_C_WORD;
      OFS_BOARD:  sel = BOARD_ID;
      default:    sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata_q <= '0;
    else if (re) rdata_q <= sel;
  end

  assign rdata = rdata_q;

  assert_id_word_R1: assert property (@(posedge clk) disable iff (rst)
    (re && addr == OFS_ID_C) |=> (rdata == 16'hCAFE));

  assert_hole_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (re && addr == 8'h18) |=> (rdata == '0));
endmodule

// File: rtl/dbg_irq_regbank.sv
module dbg_irq_regbank
  import dbg_regbank_pkg::*;
#(
  parameter int NUM_SRC  = 16,
  parameter int NUM_BTN  = 2,
  parameter int NUM_LED  = 8,
  parameter logic [15:0] VERSION  = 16'h0103,
  parameter logic [15:0] BOARD_ID = 16'h00B5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [7:0]         bus_addr,
  input  logic               bus_we,
  input  logic [15:0]        bus_wdata,
  input  logic               bus_re,
  output logic [15:0]        bus_rdata,
  input  logic [NUM_SRC-1:0] irq_req,
  input  logic [NUM_BTN-1:0] btn_in,
  output logic [NUM_LED-1:0] led_out,
  output logic               host_irq_n
);
  localparam int PAD_BTN = DATA_W - NUM_BTN;

  logic [DATA_W-1:0]  led_q;
  logic [NUM_BTN-1:0] btn_sync;
  regview_t           view;

  always_ff @(posedge clk) begin
    if (rst)                                led_q <= '0;
    else if (bus_we && bus_addr == OFS_LED) led_q <= bus_wdata;
  end

  assign led_out = led_q[NUM_LED-1:0];

  dbg_sync2 #(.W(NUM_BTN)) u_btn_sync (
    .clk (clk),
    .rst (rst),
    .d   (btn_in),
    .q   (btn_sync)
  );

  dbg_irq_core #(.NUM_SRC(NUM_SRC)) u_core (
    .clk      (clk),
    .rst      (rst),
    .mask_we  (bus_we && bus_addr == OFS_MASK),
    .clr_we   (bus_we && bus_addr == OFS_CLEAR),
    .wdata    (bus_wdata),
    .irq_req  (irq_req),
    .status_o (view.status),
    .mask_o   (view.mask),
    .clr_o    (view.clear),
    .irq_n    (host_irq_n)
  );

  assign view.led = led_q;

  generate
    if (PAD_BTN > 0) begin : g_btn_pad
      assign view.btn = {{PAD_BTN{1'b0}}, btn_sync};
    end else begin : g_btn_full
      assign view.btn = btn_sync;
    end
  endgenerate

  dbg_read_mux #(.VERSION(VERSION), .BOARD_ID(BOARD_ID)) u_rd (
    .clk   (clk),
    .rst   (rst),
    .re    (bus_re),
    .addr  (bus_addr),
    .regs  (view),
    .rdata (bus_rdata)
  );

  initial begin
    assert (NUM_SRC >= 1 && NUM_SRC <= DATA_W && NUM_BTN >= 1 && NUM_BTN <= DATA_W
            && NUM_LED >= 1 && NUM_LED <= DATA_W)
      else $error("parameter out of range");
  end

  assert_led_drive_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == OFS_LED) |=> (led_out == $past(bus_wdata[NUM_LED-1:0])));
endmodule

// File: tb/dbg_irq_regbank_test.sv
module dbg_irq_regbank_test;
  localparam int CLK_PERIOD = 10;
  localparam int NTAB = 12;

  localparam logic [7:0] T_ADDR [NTAB] = '{
    8'h40, 8'h48, 8'h58, 8'h50, 8'h68, 8'h38,
    8'h10, 8'h20, 8'h00, 8'h18, 8'h30, 8'hFE};
  localparam logic [15:0] T_EXP [NTAB] = '{
    16'hAAAA, 16'h5555, 16'hCAFE, 16'h0103, 16'h00B5, 16'hFFFF,
    16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000};
  localparam string T_REQ [NTAB] = '{
    "R1", "R1", "R1", "R2", "R2", "R4",
    "R4", "R4", "R4", "R3", "R3", "R3"};

  logic        clk = 0;
  logic        rst = 1;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 0;
  logic [15:0] bus_wdata = '0;
  logic        bus_re = 0;
  logic [15:0] bus_rdata;
  logic [15:0] irq_req = '0;
  logic [1:0]  btn_in = '0;
  logic [7:0]  led_out;
  logic        host_irq_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_irq_regbank uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .irq_req(irq_req), .btn_in(btn_in), .led_out(led_out),
    .host_irq_n(host_irq_n));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [15:0] exp);
    bus_addr = a; bus_re = 1;
    @(negedge clk);
    bus_re = 0;
    check(req, bus_rdata, exp);
  endtask

  initial begin
    tick(3);
    rst = 0;
    tick(1);
    check("R4", {15'd0, host_irq_n}, 16'h0001);

    // table walk: identification words, reset values, holes
    for (int i = 0; i < NTAB; i++) rd(T_REQ[i], T_ADDR[i], T_EXP[i]);

    // R1 R2: writes to read-only words are ignored
    wr(8'h48, 16'h1234);
    rd("R1", 8'h48, 16'h5555);
    wr(8'h50, 16'hFFFF);
    rd("R2", 8'h50, 16'h0103);

    // R10: LED register
    wr(8'h00, 16'hA55A);
    check("R10", {8'd0, led_out}, 16'h005A);
    rd("R10", 8'h00, 16'hA55A);

    // R5 R8: single source, mask open
    wr(8'h38, 16'h0000);
    irq_req = 16'h0004;
    tick(1);
    check("R8", {15'd0, host_irq_n}, 16'h0001);
    tick(1);
    check("R8", {15'd0, host_irq_n}, 16'h0000);
    irq_req = 16'h0000;
    tick(2);
    rd("R5", 8'h10, 16'h0004);
    check("R5", {15'd0, host_irq_n}, 16'h0000);

    // R7: masked source keeps line high, status still visible
    wr(8'h38, 16'h0004);
    tick(1);
    check("R7", {15'd0, host_irq_n}, 16'h0001);
    rd("R7", 8'h10, 16'h0004);

    // R6: clear held while request stays high
    wr(8'h38, 16'h0000);
    wr(8'h20, 16'h0004);
    irq_req = 16'h0004;
    tick(3);
    rd("R6", 8'h10, 16'h0000);
    check("R6", {15'd0, host_irq_n}, 16'h0001);
    wr(8'h20, 16'h0000);
    tick(2);
    rd("R6", 8'h10, 16'h0004);
    irq_req = 16'h0000;

    // R9: host start-up sequence
    wr(8'h38, 16'h0000);
    wr(8'h20, 16'hFFFF);
    wr(8'h20, 16'h0000);
    wr(8'h38, 16'h001F);
    tick(2);
    rd("R9", 8'h10, 16'h0000);
    rd("R9", 8'h38, 16'h001F);
    check("R9", {15'd0, host_irq_n}, 16'h0001);
    irq_req = 16'h0009;
    tick(3);
    check("R9", {15'd0, host_irq_n}, 16'h0001);
    irq_req = 16'h0080;
    tick(2);
    check("R9", {15'd0, host_irq_n}, 16'h0000);
    rd("R9", 8'h10, 16'h0089);
    irq_req = 16'h0000;

    // R11: button synchronizer depth
    btn_in = 2'b10;
    rd("R11", 8'h08, 16'h0000);
    tick(2);
    rd("R11", 8'h08, 16'h0002);

    // R4: reset restores defaults
    rst = 1;
    tick(1);
    rst = 0;
    rd("R4", 8'h38, 16'hFFFF);
    rd("R4", 8'h10, 16'h0000);
    check("R4", {15'd0, host_irq_n}, 16'h0001);
    check("R4", {8'd0, led_out}, 16'h0000);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule